// File: doc/BRIEF.md
# Link Integrity Trip Supervisor

This block judges the health of a serial control link from the verdicts a frame receiver hands it. It keeps two fault tallies: one for frames that broke protocol, and one for periodic integrity frames that failed to arrive within their 720 Hz slot. Each integrity frame carries two trip limits, which the block adopts when the frame arrives. When either tally reaches its limit, the block drops its permit output and raises an interrupt request. The permit then stays low until a link-clear frame arrives or the block is reset.

A slow window, 2.5 s by default, splits time into reporting intervals. At each window edge, both tallies are copied into readable count outputs and the tallies restart from zero. A flag reports that a clear or reset has happened since the last window edge. Frame decoding happens upstream. Every event input is a one-cycle pulse. The interface has no streaming data, so it has no valid/ready handshake. All pins are plain control and status pins.

Top module: `link_trip_supervisor`

## Requirements
- R1: After reset, the block presents the following state:
  - `permit` is 1 and `irq` is 0.
  - Both latched counts are 0 and `cleared_seen` is 1.
  - Both trip limits are 0.
- R2: A pulse on `integ_frame` loads `integ_bad_thr` (8 bits) as the bad-frame limit and `integ_miss_thr` (4 bits) as the missing-frame limit. A limit of 0 disables that comparison.
- R3: Each cycle with `bad_frame` high adds one to the bad tally. At the clock edge where the tally reaches a non-zero limit, `permit` goes to 0.
- R4: The missing tally stays idle until the first `integ_frame` after reset. After that, on every slot tick (one every TICK_CYCLES cycles, the first at the TICK_CYCLES-th edge after reset), the tally adds one if no integrity frame came since the previous tick. Reaching a non-zero limit drops `permit` in the same way as R3.
- R5: Once low, `permit` stays low across window edges until a clear or a reset.
- R6: A `clear_frame` pulse has these effects:
  - `permit` returns to 1 at the next edge.
  - Both tallies are zeroed.
  - The clear takes precedence over fault events in the same cycle.
- R7: Every WINDOW_TICKS slot ticks, a window edge copies each tally into its count output. The copied value includes the events of that same cycle. The tallies then restart at 0.
- R8: Tallies saturate: the bad tally at 255 and the missing tally at 15.
- R9: `irq` is 1 exactly while `permit` is 0.
- R10: `cleared_seen` is set by reset or by `clear_frame`. It is cleared at the next window edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bad_frame | input | 1 | Pulse: one frame broke protocol |
| integ_frame | input | 1 | Pulse: a valid integrity frame arrived |
| integ_bad_thr | input | 8 | Bad-frame limit carried by the integrity frame |
| integ_miss_thr | input | 4 | Missing-frame limit carried by the integrity frame |
| clear_frame | input | 1 | Pulse: a link-clear frame arrived |
| permit | output | 1 | Link permit, 0 when tripped |
| irq | output | 1 | Interrupt request while tripped |
| bad_count | output | 8 | Bad-frame tally latched at the last window edge |
| miss_count | output | 4 | Missing-frame tally latched at the last window edge |
| cleared_seen | output | 1 | Clear or reset occurred since the last window edge |

## Verification
The bench sends 260 consecutive bad frames into one window and expects a report of 255. A design that wraps would report 4. Before any integrity frame has arrived, the bench expects a missing count of 0; a design that counts unarmed slots would report 15. The bench then holds one integrity frame per slot across a whole window and expects no misses. A design that mis-handles the slot straddling the window edge would show a stray count. The bench also expects a trip to survive a window edge, which catches a permit that re-arms on its own. Finally, it expects a mid-window clear to discard earlier faults, so a design that keeps them would report the wrong total.

// File: rtl/lts_pkg.sv
package lts_pkg;
  localparam int unsigned BAD_W  = 8;
  localparam int unsigned MISS_W = 4;
endpackage

// File: rtl/lts_divider.sv
module lts_divider #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic pulse
);
  localparam int unsigned W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  assign pulse = en && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= pulse ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/lts_fault_counter.sv
module lts_fault_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  input  logic         boundary,
  input  logic [W-1:0] thr,
  output logic         hit,
  output logic [W-1:0] latched
);
  localparam logic [W-1:0] MAXV = '1;

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_nx;
  logic [W-1:0] lat_q;

  always_comb begin
    if (clr)                        cnt_nx = '0;
    else if (inc && cnt_q != MAXV)  cnt_nx = cnt_q + 1'b1;
    else                            cnt_nx = cnt_q;
  end

  assign hit     = (thr != '0) && (cnt_nx >= thr);
  assign latched = lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lat_q <= '0;
    end else begin
      cnt_q <= boundary ? '0 : cnt_nx;
      if (boundary) lat_q <= cnt_nx;
    end
  end
endmodule

// File: rtl/link_trip_supervisor.sv
module link_trip_supervisor
  import lts_pkg::*;
#(
  parameter int unsigned TICK_CYCLES  = 69444,
  parameter int unsigned WINDOW_TICKS = 1800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bad_frame,
  input  logic              integ_frame,
  input  logic [BAD_W-1:0]  integ_bad_thr,
  input  logic [MISS_W-1:0] integ_miss_thr,
  input  logic              clear_frame,
  output logic              permit,
  output logic              irq,
  output logic [BAD_W-1:0]  bad_count,
  output logic [MISS_W-1:0] miss_count,
  output logic              cleared_seen
);
  logic              tick;
  logic              win_pulse;
  logic              armed_q;
  logic              seen_q;
  logic              miss_inc;
  logic              bad_hit;
  logic              miss_hit;
  logic              permit_q;
  logic              cleared_q;
  logic [BAD_W-1:0]  bad_thr_q;
  logic [MISS_W-1:0] miss_thr_q;

  lts_divider #(.LIMIT(TICK_CYCLES)) u_slot (
    .clk(clk), .rst_n(rst_n), .en(1'b1), .pulse(tick)
  );

  lts_divider #(.LIMIT(WINDOW_TICKS)) u_window (
    .clk(clk), .rst_n(rst_n), .en(tick), .pulse(win_pulse)
  );

  // a slot is missed when it closes with no integrity frame in it
  assign miss_inc = tick && armed_q && !seen_q && !integ_frame;

  lts_fault_counter #(.W(BAD_W)) u_bad (
    .clk(clk), .rst_n(rst_n), .clr(clear_frame), .inc(bad_frame),
    .boundary(win_pulse), .thr(bad_thr_q), .hit(bad_hit), .latched(bad_count)
  );

  lts_fault_counter #(.W(MISS_W)) u_miss (
    .clk(clk), .rst_n(rst_n), .clr(clear_frame), .inc(miss_inc),
    .boundary(win_pulse), .thr(miss_thr_q), .hit(miss_hit), .latched(miss_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q    <= 1'b0;
      seen_q     <= 1'b0;
      bad_thr_q  <= '0;
      miss_thr_q <= '0;
      permit_q   <= 1'b1;
      cleared_q  <= 1'b1;
    end else begin
      armed_q <= armed_q | integ_frame;
      seen_q  <= tick ? 1'b0 : (seen_q | integ_frame);
      if (integ_frame) begin
        bad_thr_q  <= integ_bad_thr;
        miss_thr_q <= integ_miss_thr;
      end
      if (clear_frame)            permit_q <= 1'b1;
      else if (bad_hit || miss_hit) permit_q <= 1'b0;
      if (clear_frame)    cleared_q <= 1'b1;
      else if (win_pulse) cleared_q <= 1'b0;
    end
  end

  assign permit       = permit_q;
  assign irq          = !permit_q;
  assign cleared_seen = cleared_q;
endmodule

// File: rtl/lts_checker.sv
module lts_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       bad_frame,
  input logic       clear_frame,
  input logic       permit,
  input logic       irq,
  input logic       cleared_seen,
  input logic       miss_pulse,
  input logic       boundary,
  input logic [7:0] bad_cnt
);
  AST_CLEAR_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
    clear_frame |=> permit); // R6

  AST_TRIP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!permit && !clear_frame) |=> !permit); // R5

  AST_TRIP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(permit) |-> $past(bad_frame || miss_pulse)); // R3

  AST_IRQ_WHILE_TRIPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !permit |-> irq); // R9

  AST_CLEAR_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    clear_frame |=> cleared_seen); // R10

  AST_WINDOW_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> (bad_cnt == 8'd0)); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_cnt == 8'hFF && bad_frame && !clear_frame && !boundary) |=> (bad_cnt == 8'hFF)); // R8
endmodule

bind link_trip_supervisor lts_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bad_frame(bad_frame), .clear_frame(clear_frame),
  .permit(permit), .irq(irq), .cleared_seen(cleared_seen),
  .miss_pulse(miss_inc), .boundary(win_pulse), .bad_cnt(u_bad.cnt_q)
);

// File: tb/sim_link_trip_supervisor.sv
module sim_link_trip_supervisor;
  localparam int CLK_PERIOD = 10;
  localparam int TICKC = 10;
  localparam int WINT  = 40;
  localparam int WINC  = TICKC * WINT;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bad_frame = 1'b0;
  logic       integ_frame = 1'b0;
  logic [7:0] integ_bad_thr = '0;
  logic [3:0] integ_miss_thr = '0;
  logic       clear_frame = 1'b0;
  logic       permit, irq, cleared_seen;
  logic [7:0] bad_count;
  logic [3:0] miss_count;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  link_trip_supervisor #(.TICK_CYCLES(TICKC), .WINDOW_TICKS(WINT)) u0 (
    .clk(clk), .rst_n(rst_n), .bad_frame(bad_frame), .integ_frame(integ_frame),
    .integ_bad_thr(integ_bad_thr), .integ_miss_thr(integ_miss_thr),
    .clear_frame(clear_frame), .permit(permit), .irq(irq),
    .bad_count(bad_count), .miss_count(miss_count), .cleared_seen(cleared_seen)
  );

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic sync_window();
    @(negedge clk);
    while (cyc % WINC != 0) @(negedge clk);
  endtask

  task automatic send_bad(input int n);
    bad_frame = 1'b1;
    repeat (n) @(negedge clk);
    bad_frame = 1'b0;
  endtask

  task automatic send_clear();
    clear_frame = 1'b1;
    @(negedge clk);
    clear_frame = 1'b0;
  endtask

  task automatic send_integ(input int bthr, input int mthr);
    integ_bad_thr  = 8'(bthr);
    integ_miss_thr = 4'(mthr);
    integ_frame = 1'b1;
    @(negedge clk);
    integ_frame = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 permit", permit, 1);
    check("R1/R9 irq", irq, 0);
    check("R1 bad_count", bad_count, 0);
    check("R1 miss_count", miss_count, 0);
    check("R1 cleared_seen", cleared_seen, 1);
  endtask

  task automatic t_unarmed_window();
    sync_window();
    check("R4 no misses before first integrity frame", miss_count, 0);
    check("R7 empty window bad", bad_count, 0);
    check("R10 flag falls at window edge", cleared_seen, 0);
  endtask

  task automatic t_clear_mid_window();
    sync_window();
    send_bad(5);
    send_clear();
    check("R10 flag set by clear", cleared_seen, 1);
    send_bad(2);
    sync_window();
    check("R6/R7 only post-clear faults latched", bad_count, 2);
    check("R10 flag cleared at edge", cleared_seen, 0);
  endtask

  task automatic t_bad_saturate();
    sync_window();
    send_bad(260);
    sync_window();
    check("R8 bad count saturates", bad_count, 255);
    check("R2 zero limit disables trip", permit, 1);
  endtask

  task automatic t_bad_trip();
    send_integ(3, 0);
    sync_window();
    send_bad(2);
    check("R3 below limit keeps permit", permit, 1);
    send_bad(1);
    check("R3 trips at limit", permit, 0);
    check("R9 irq while tripped", irq, 1);
  endtask

  task automatic t_sticky_then_clear();
    sync_window();
    check("R5 trip survives window edge", permit, 0);
    send_clear();
    check("R6 clear restores permit", permit, 1);
    check("R9 irq drops", irq, 0);
    check("R10 flag after clear", cleared_seen, 1);
  endtask

  task automatic t_miss_saturate();
    sync_window();
    sync_window();
    check("R8 miss count saturates", miss_count, 15);
    check("R7 bad count idle window", bad_count, 0);
  endtask

  task automatic t_miss_trip();
    sync_window();
    send_integ(0, 2);
    repeat (14) @(negedge clk);
    check("R4 one slot seen, no trip yet", permit, 1);
    repeat (20) @(negedge clk);
    check("R4 trip after two missed slots", permit, 0);
  endtask

  task automatic t_integ_every_slot();
    sync_window();
    send_clear();
    for (int k = 0; k < WINT; k++) begin
      send_integ(0, 2);
      repeat (TICKC - 1) @(negedge clk);
    end
    check("R4 no misses with frame each slot", miss_count, 0);
    check("R4 permit held", permit, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_unarmed_window();
    t_clear_mid_window();
    t_bad_saturate();
    t_bad_trip();
    t_sticky_then_clear();
    t_miss_saturate();
    t_miss_trip();
    t_integ_every_slot();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule